// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Aligner

This block sits between a processor core and a data memory that is one word wide. On a load it receives the word fetched from memory and turns it into the value the register file should receive. Bytes and halfwords are picked out of their lanes and then sign- or zero-extended. The two partial-word merge loads combine memory bytes with the old destination register value. On a store it takes the source register value and places its bytes in the right memory lanes, together with a per-lane write-enable mask.

Lanes use big-endian numbering. Address offset 0 is the most significant byte of the word. The block receives only the low address bits. Computing the effective address and the memory itself belong to the surrounding core. Misaligned halfword and word accesses raise an alignment error in place of any result or write. All outputs are registered, so each result appears one clock after its inputs.

Top module: `lsa_align_unit`

## Requirements
- R1: Outputs are registered and reflect the inputs of the previous clock. While the synchronous active-high reset is applied, every output is zero.
- R2: Byte lane for offset k sits at bits [31-8k -: 8] of the word (offset 0 = bits 31..24, offset 3 = bits 7..0). Store enable bit 3 belongs to offset 0 and bit 0 to offset 3.
- R3: Operation code 1 loads the addressed byte sign-extended from its bit 7. Code 2 loads it zero-extended. Neither code ever raises the alignment error.
- R4: Code 3 loads the halfword at offsets k and k+1 sign-extended, and code 4 loads it zero-extended. An odd offset is misaligned.
- R5: Code 5 loads the whole memory word, and only at offset 0.
- R6: Code 6 (left merge load) at offset k puts memory bytes k..3 into the top 4-k register bytes. It keeps the low k bytes of the old register value.
- R7: Code 7 (right merge load) at offset k puts memory bytes 0..k into the low k+1 register bytes. It keeps the upper 3-k bytes of the old register value.
- R8: Code 8 stores register bits 7..0 to lane k. Code 9 stores bits 15..0 to lanes k,k+1 and requires an even k. Code 10 stores the full word and requires k=0. Lanes not enabled carry zero data.
- R9: Code 11 (left merge store) at offset k writes register bytes from the most significant one down into lanes k..3, enabling just those lanes.
- R10: Code 12 (right merge store) at offset k writes the low k+1 register bytes into lanes 0..k, enabling just those lanes.
- R11: A misaligned code 3, 4, 5, 9 or 10 sets the alignment error. The load result, store data and enables are then all zero. Merge operations never raise the error.
- R12: For a load, the store data and enables are zero. For a store, the load result is zero. Codes 0, 13, 14 and 15 produce all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code (see requirements) |
| ofs | input | 2 | Low bits of the effective address |
| mem_word | input | 32 | Word read from data memory |
| rt_word | input | 32 | Register operand (store source / old load destination) |
| ld_data | output | 32 | Load result to the register file |
| st_data | output | 32 | Lane-placed store data |
| st_be | output | 4 | Store byte enables, bit 3 = offset 0 |
| align_err | output | 1 | Misaligned halfword or word access |

## Verification
The bench builds the block with its default geometry of four eight-bit lanes. At that size every operation code, including the unused ones, can be crossed with every address offset, and the whole space is applied exhaustively. Each combination is driven with several memory and register patterns. Together these patterns set and clear the sign bit of every lane and leave distinct bytes in every lane, so a lane swap, a wrong merge boundary or a missed sign extension shows up in the compared word.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int LSA_BYTE_W = 8;
    localparam int LSA_LANES  = 4;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_LB   = 4'd1,
        OP_LBU  = 4'd2,
        OP_LH   = 4'd3,
        OP_LHU  = 4'd4,
        OP_LW   = 4'd5,
        OP_LWL  = 4'd6,
        OP_LWR  = 4'd7,
        OP_SB   = 4'd8,
        OP_SH   = 4'd9,
        OP_SW   = 4'd10,
        OP_SWL  = 4'd11,
        OP_SWR  = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        MD_PLAIN = 2'd0,
        MD_LEFT  = 2'd1,
        MD_RIGHT = 2'd2
    } mode_e;

    typedef struct packed {
        logic  is_load;
        logic  is_store;
        logic  sext;
        size_e size;
        mode_e mode;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [3:0] code);
        op_dec_t d;
        d.is_load  = 1'b0;
        d.is_store = 1'b0;
        d.sext     = 1'b0;
        d.size     = SZ_BYTE;
        d.mode     = MD_PLAIN;
        case (code)
            OP_LB:  begin d.is_load = 1'b1; d.sext = 1'b1; end
            OP_LBU: begin d.is_load = 1'b1; end
            OP_LH:  begin d.is_load = 1'b1; d.sext = 1'b1; d.size = SZ_HALF; end
            OP_LHU: begin d.is_load = 1'b1; d.size = SZ_HALF; end
            OP_LW:  begin d.is_load = 1'b1; d.size = SZ_WORD; end
            OP_LWL: begin d.is_load = 1'b1; d.mode = MD_LEFT; end
            OP_LWR: begin d.is_load = 1'b1; d.mode = MD_RIGHT; end
            OP_SB:  begin d.is_store = 1'b1; end
            OP_SH:  begin d.is_store = 1'b1; d.size = SZ_HALF; end
            OP_SW:  begin d.is_store = 1'b1; d.size = SZ_WORD; end
            OP_SWL: begin d.is_store = 1'b1; d.mode = MD_LEFT; end
            OP_SWR: begin d.is_store = 1'b1; d.mode = MD_RIGHT; end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsa_load_path.sv
module lsa_load_path
    import lsa_pkg::*;
#(
    parameter int BYTE_W = LSA_BYTE_W,
    parameter int LANES  = LSA_LANES,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int OFS_W  = $clog2(LANES)
) (
    input  op_dec_t           dec,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] rt_word,
    output logic [WORD_W-1:0] result
);

    function automatic logic [BYTE_W-1:0] lane_of(input logic [WORD_W-1:0] w, input int idx);
        return w[(LANES-1-idx)*BYTE_W +: BYTE_W];
    endfunction

    logic [BYTE_W-1:0]   sel_byte;
    logic [2*BYTE_W-1:0] sel_half;

    always_comb begin
        int k;
        k        = int'(ofs);
        result   = '0;
        sel_byte = lane_of(mem_word, k);
        sel_half = '0;
        if (k + 1 < LANES) begin
            sel_half = {lane_of(mem_word, k), lane_of(mem_word, k + 1)};
        end
        if (dec.is_load) begin
            case (dec.mode)
                MD_PLAIN: begin
                    case (dec.size)
                        SZ_BYTE: result = {{(WORD_W-BYTE_W){dec.sext & sel_byte[BYTE_W-1]}}, sel_byte};
                        SZ_HALF: result = {{(WORD_W-2*BYTE_W){dec.sext & sel_half[2*BYTE_W-1]}}, sel_half};
                        default: result = mem_word;
                    endcase
                end
                MD_LEFT: begin
                    for (int j = 0; j < LANES; j++) begin
                        if (j + k < LANES) begin
                            result[(LANES-1-j)*BYTE_W +: BYTE_W] = lane_of(mem_word, j + k);
                        end else begin
                            result[(LANES-1-j)*BYTE_W +: BYTE_W] = lane_of(rt_word, j);
                        end
                    end
                end
                MD_RIGHT: begin
                    for (int j = 0; j < LANES; j++) begin
                        if (j >= LANES - 1 - k) begin
                            result[(LANES-1-j)*BYTE_W +: BYTE_W] = lane_of(mem_word, j - (LANES - 1 - k));
                        end else begin
                            result[(LANES-1-j)*BYTE_W +: BYTE_W] = lane_of(rt_word, j);
                        end
                    end
                end
                default: result = '0;
            endcase
        end
    end

endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path
    import lsa_pkg::*;
#(
    parameter int BYTE_W = LSA_BYTE_W,
    parameter int LANES  = LSA_LANES,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int OFS_W  = $clog2(LANES)
) (
    input  op_dec_t           dec,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] rt_word,
    output logic [WORD_W-1:0] data,
    output logic [LANES-1:0]  be
);

    function automatic logic [BYTE_W-1:0] lane_of(input logic [WORD_W-1:0] w, input int idx);
        return w[(LANES-1-idx)*BYTE_W +: BYTE_W];
    endfunction

    always_comb begin
        int k;
        int src;
        k    = int'(ofs);
        data = '0;
        be   = '0;
        if (dec.is_store) begin
            for (int m = 0; m < LANES; m++) begin
                src = -1;
                case (dec.mode)
                    MD_PLAIN: begin
                        case (dec.size)
                            SZ_BYTE: if (m == k) src = LANES - 1;
                            SZ_HALF: begin
                                if (m == k)     src = LANES - 2;
                                if (m == k + 1) src = LANES - 1;
                            end
                            default: src = m;
                        endcase
                    end
                    MD_LEFT:  if (m >= k) src = m - k;
                    MD_RIGHT: if (m <= k) src = m + LANES - 1 - k;
                    default:  src = -1;
                endcase
                if (src >= 0) begin
                    data[(LANES-1-m)*BYTE_W +: BYTE_W] = lane_of(rt_word, src);
                    be[LANES-1-m] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit
    import lsa_pkg::*;
#(
    parameter int BYTE_W = LSA_BYTE_W,
    parameter int LANES  = LSA_LANES,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int OFS_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] rt_word,
    output logic [WORD_W-1:0] ld_data,
    output logic [WORD_W-1:0] st_data,
    output logic [LANES-1:0]  st_be,
    output logic              align_err
);

    op_dec_t           dec;
    logic              misaligned;
    logic [WORD_W-1:0] ld_raw;
    logic [WORD_W-1:0] st_raw;
    logic [LANES-1:0]  be_raw;

    assign dec = decode_op(op);

    always_comb begin
        misaligned = 1'b0;
        if ((dec.is_load || dec.is_store) && dec.mode == MD_PLAIN) begin
            if (dec.size == SZ_HALF) misaligned = ofs[0];
            if (dec.size == SZ_WORD) misaligned = (ofs != '0);
        end
    end

    lsa_load_path #(.BYTE_W(BYTE_W), .LANES(LANES)) u_load (
        .dec      (dec),
        .ofs      (ofs),
        .mem_word (mem_word),
        .rt_word  (rt_word),
        .result   (ld_raw)
    );

    lsa_store_path #(.BYTE_W(BYTE_W), .LANES(LANES)) u_store (
        .dec     (dec),
        .ofs     (ofs),
        .rt_word (rt_word),
        .data    (st_raw),
        .be      (be_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_data   <= '0;
            st_data   <= '0;
            st_be     <= '0;
            align_err <= 1'b0;
        end else begin
            ld_data   <= misaligned ? '0 : ld_raw;
            st_data   <= misaligned ? '0 : st_raw;
            st_be     <= misaligned ? '0 : be_raw;
            align_err <= misaligned;
        end
    end

endmodule

// File: rtl/lsa_align_checker.sv
module lsa_align_checker
    import lsa_pkg::*;
#(
    parameter int BYTE_W = LSA_BYTE_W,
    parameter int LANES  = LSA_LANES,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int OFS_W  = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op,
    input logic [OFS_W-1:0]  ofs,
    input logic [WORD_W-1:0] rt_word,
    input logic [WORD_W-1:0] ld_data,
    input logic [WORD_W-1:0] st_data,
    input logic [LANES-1:0]  st_be,
    input logic              align_err
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ld_data == '0 && st_data == '0 && st_be == '0 && !align_err));

    p_err_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        align_err |-> (st_be == '0 && ld_data == '0 && st_data == '0));

    p_word_misalign_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op == OP_SW && ofs != '0)) |-> align_err);

    p_swl_full_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op == OP_SWL && ofs == '0)) |-> (st_be == '1 && st_data == $past(rt_word)));

    p_lb_sext_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op == OP_LB)) |->
        (ld_data[WORD_W-1:BYTE_W] == {(WORD_W-BYTE_W){ld_data[BYTE_W-1]}}));

    p_load_no_be_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op >= OP_LB && op <= OP_LWR)) |-> (st_be == '0 && st_data == '0));

    p_err_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op == OP_SWR)) |-> (!align_err && $countones(st_be) >= 1));

endmodule

bind lsa_align_unit lsa_align_checker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .ofs       (ofs),
    .rt_word   (rt_word),
    .ld_data   (ld_data),
    .st_data   (st_data),
    .st_be     (st_be),
    .align_err (align_err)
);

// File: tb/tb_lsa_align_unit.sv
`timescale 1ns/1ps
module tb_lsa_align_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = '0;
    logic [1:0]  ofs = '0;
    logic [31:0] mem_word = '0;
    logic [31:0] rt_word = '0;
    logic [31:0] ld_data;
    logic [31:0] st_data;
    logic [3:0]  st_be;
    logic        align_err;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    lsa_align_unit dut (
        .clk(clk), .rst(rst), .op(op), .ofs(ofs),
        .mem_word(mem_word), .rt_word(rt_word),
        .ld_data(ld_data), .st_data(st_data), .st_be(st_be), .align_err(align_err)
    );

    // Expected outputs, computed from the requirements with shifts and masks
    logic [31:0] e_ld, e_st;
    logic [3:0]  e_be;
    logic        e_err;
    string       e_tag;

    task automatic model(input int o, input int k, input logic [31:0] rd, input logic [31:0] rt);
        logic [63:0] t;
        logic [7:0]  b;
        logic [15:0] h;
        e_ld = 0; e_st = 0; e_be = 0; e_err = 0; e_tag = "R12";
        case (o)
            1, 2: begin
                e_tag = "R2/R3";
                b = 8'(rd >> (8 * (3 - k)));
                e_ld = (o == 1) ? 32'(signed'(b)) : {24'd0, b};
            end
            3, 4: begin
                e_tag = "R4";
                if (k % 2 == 1) begin e_err = 1; e_tag = "R11"; end
                else begin
                    h = 16'(rd >> (8 * (2 - k)));
                    e_ld = (o == 3) ? 32'(signed'(h)) : {16'd0, h};
                end
            end
            5: begin
                e_tag = "R5";
                if (k != 0) begin e_err = 1; e_tag = "R11"; end else e_ld = rd;
            end
            6: begin
                e_tag = "R6";
                t = ({32'd0, rd} << (8 * k)) | ({32'd0, rt} & ((64'd1 << (8 * k)) - 1));
                e_ld = t[31:0];
            end
            7: begin
                e_tag = "R7";
                t = ({32'd0, rd} >> (8 * (3 - k))) | ({32'd0, rt} & ~((64'd1 << (8 * (k + 1))) - 1));
                e_ld = t[31:0];
            end
            8: begin
                e_tag = "R8";
                e_st = {24'd0, rt[7:0]} << (8 * (3 - k));
                e_be = 4'b1000 >> k;
            end
            9: begin
                e_tag = "R8";
                if (k % 2 == 1) begin e_err = 1; e_tag = "R11"; end
                else begin
                    e_st = {16'd0, rt[15:0]} << (8 * (2 - k));
                    e_be = 4'b1100 >> k;
                end
            end
            10: begin
                e_tag = "R8";
                if (k != 0) begin e_err = 1; e_tag = "R11"; end
                else begin e_st = rt; e_be = 4'hF; end
            end
            11: begin
                e_tag = "R9";
                e_st = rt >> (8 * k);
                e_be = 4'hF >> k;
            end
            12: begin
                e_tag = "R10";
                e_st = rt << (8 * (3 - k));
                e_be = 4'((4'hF << (3 - k)) & 4'hF);
            end
            default: e_tag = "R12";
        endcase
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (ld_data !== e_ld || st_data !== e_st || st_be !== e_be || align_err !== e_err) begin
            n_fail++;
            $display("FAIL %s: got ld=%h st=%h be=%b err=%b expected ld=%h st=%h be=%b err=%b",
                     tag, ld_data, st_data, st_be, align_err, e_ld, e_st, e_be, e_err);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    logic [31:0] pat_rd [4] = '{32'h8192A3B4, 32'h01234567, 32'h7F80FF00, 32'hFFFFFFFF};
    logic [31:0] pat_rt [4] = '{32'hC5D6E7F8, 32'h89ABCDEF, 32'h00000000, 32'h13579BDF};

    initial begin
        bit have_prev;
        string prev_tag;
        // R1: reset clears outputs even with active stimulus
        @(negedge clk);
        op = 4'd10; ofs = 2'd0; mem_word = 32'hDEADBEEF; rt_word = 32'hCAFEF00D;
        @(negedge clk);
        @(negedge clk);
        e_ld = 0; e_st = 0; e_be = 0; e_err = 0;
        compare("R1 reset");
        rst = 1'b0;
        have_prev = 0;
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 16; o++) begin
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    if (have_prev) compare(prev_tag);
                    op = 4'(o); ofs = 2'(k); mem_word = pat_rd[p]; rt_word = pat_rt[p];
                    model(o, k, pat_rd[p], pat_rt[p]);
                    prev_tag = e_tag;
                    have_prev = 1;
                end
            end
        end
        @(negedge clk);
        compare(prev_tag);
        // R1: one-cycle latency, new reset clears again
        rst = 1'b1;
        @(negedge clk);
        e_ld = 0; e_st = 0; e_be = 0; e_err = 0;
        compare("R1 reset again");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule